// File: doc/BRIEF.md
# Cascaded Programmable Clock Prescaler

This block takes a fast external master clock and derives the slower internal master clock rate for a converter core. It does this without making a new clock. Three divider stages sit in series. Each stage has its own 2-bit select and advances only when the stage before it lets a pulse through. The last stage produces a one-cycle clock enable, `imclkEn`. The rest of the chip uses this enable to qualify logic that runs on the master clock.

An 8-bit counter counts the internal enables and produces two sample strobes. One fires once every 256 internal enables, for the normal sample rate. The other fires once every 128, for a low-latency mode in which less filtering is done. The `lowDelayEn` input selects which of the two appears on `sampleStb`.

Whenever any stage select changes, every counter restarts from zero, so the outputs never emit a shortened period. Reset works the same way as a select change.

Top module: `mclk_prescale_chain`

## Requirements
- R1: While `rstN` is low, `imclkEn`, `fullRateStb`, `halfRateStb` and `sampleStb` are all low. After release, the first `imclkEn` arrives on the D-th rising edge after release, where D is the overall divide.
- R2: Stage 1 and stage 2 selects encode 2'b00 as divide by 1, 2'b01 as divide by 2 and 2'b10 as divide by 3.
- R3: The stage 3 select encodes 2'b00 as divide by 1, 2'b01 as divide by 2 and 2'b10 as divide by 4.
- R4: Select value 2'b11 on any stage acts as divide by 1. With every stage at divide by 1, `imclkEn` is high on every cycle.
- R5: With steady selects, `imclkEn` is a single-cycle pulse repeating every D cycles, where D is the product of the three stage ratios.
- R6: `fullRateStb` is high together with every 256th `imclkEn` pulse counted from a restart, and is low at all other times.
- R7: `halfRateStb` is high together with every 128th `imclkEn` pulse counted from a restart, so it also fires whenever `fullRateStb` does.
- R8: `sampleStb` follows `halfRateStb` when `lowDelayEn` is high and follows `fullRateStb` when it is low. Changing `lowDelayEn` does not restart any counter.
- R9: In the cycle in which a changed select is first present, all outputs are low. The first `imclkEn` at the new ratio comes on the D-th rising edge, counting the edge that first samples the new value, with no enable in between.
- R10: Selecting divide by 3, 2 and 1 gives D = 6, so `fullRateStb` first fires 1536 cycles after the restart edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | External master clock |
| rstN | input | 1 | Active-low synchronous reset |
| stage1Sel | input | 2 | Ratio select of the first divider stage |
| stage2Sel | input | 2 | Ratio select of the second divider stage |
| stage3Sel | input | 2 | Ratio select of the third divider stage |
| lowDelayEn | input | 1 | Routes the 1/128 strobe to `sampleStb` when high |
| imclkEn | output | 1 | Enable pulse at the internal master clock rate |
| fullRateStb | output | 1 | Strobe once per 256 internal enables |
| halfRateStb | output | 1 | Strobe once per 128 internal enables |
| sampleStb | output | 1 | Mode-selected sample strobe |

## Verification
The bench changes selects in the middle of a count. A design that failed to restart, or that let the old terminal count meet the new ratio, would emit an early or doubled `imclkEn` in the change cycle or shortly after it.

The asymmetric ratio sets are tested on every stage, including the spare encoding. A design that decoded the third stage like the first two would produce a divide by 3 where a divide by 4 is expected. A spare code left undecoded would stall or misdivide.

The strobe positions are measured in absolute cycles from the restart edge at 1536, 768 and 128 cycles. An off-by-one in the 8-bit counter, or a swapped low-latency mux, would shift the first strobe or change how many strobes appear in a window.

// File: rtl/prescale_pkg.sv
package prescale_pkg;

  localparam int STAGES   = 3;
  localparam int SEL_W    = 2;
  localparam int CNT_W    = 2;
  localparam int SAMPLE_W = 8;

  typedef enum logic [SEL_W-1:0] {
    SEL_PASS  = 2'b00,
    SEL_HALF  = 2'b01,
    SEL_WIDE  = 2'b10,
    SEL_SPARE = 2'b11
  } stageSel_e;

  // Control to datapath: restart request plus per-stage terminal counts.
  typedef struct packed {
    logic                         restart;
    logic [STAGES-1:0][CNT_W-1:0] termCnt;
  } ctrlStrobes_t;

  // Terminal count (ratio minus one) for one stage.
  // The last stage uses the wide ratio 4; the others use 3.
  function automatic logic [CNT_W-1:0] termFor(input logic isLast,
                                              input logic [SEL_W-1:0] sel);
    logic [CNT_W-1:0] t;
    case (stageSel_e'(sel))
      SEL_HALF: t = CNT_W'(1);
      SEL_WIDE: t = isLast ? CNT_W'(3) : CNT_W'(2);
      default:  t = '0;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/prescale_ctrl.sv
module prescale_ctrl
  import prescale_pkg::*;
#(
  parameter int NUM_STAGES = STAGES
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_STAGES-1:0][SEL_W-1:0] stageSel,
  output ctrlStrobes_t                     strobes
);

  logic [NUM_STAGES-1:0][SEL_W-1:0] selQ;
  logic                             runQ;
  logic                             selChanged;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ <= '0;
      runQ <= 1'b0;
    end else begin
      selQ <= stageSel;
      runQ <= 1'b1;
    end
  end

  assign selChanged      = (stageSel != selQ);
  assign strobes.restart = selChanged || !runQ || !rstN;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : gTerm
    localparam logic IS_LAST = (g == NUM_STAGES - 1);
    assign strobes.termCnt[g] = termFor(IS_LAST, stageSel[g]);
  end

  // R9
  restart_settle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restart |=> (!strobes.restart || !$stable(stageSel)));

endmodule

// File: rtl/prescale_datapath.sv
module prescale_datapath
  import prescale_pkg::*;
#(
  parameter int NUM_STAGES = STAGES,
  parameter int CW         = CNT_W,
  parameter int SW         = SAMPLE_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic         lowDelayEn,
  output logic         imclkEn,
  output logic         fullRateStb,
  output logic         halfRateStb,
  output logic         sampleStb
);

  localparam int HALF_W = SW - 1;

  logic [NUM_STAGES:0]           stageIn;
  logic [NUM_STAGES-1:0][CW-1:0] stageCnt;
  logic [SW-1:0]                 sampleCnt;

  assign stageIn[0] = 1'b1;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : gStage
    logic atTerm;
    assign atTerm       = (stageCnt[g] == strobes.termCnt[g]);
    assign stageIn[g+1] = stageIn[g] && atTerm;

    always_ff @(posedge clk) begin
      if (!rstN || strobes.restart) begin
        stageCnt[g] <= '0;
      end else if (stageIn[g]) begin
        stageCnt[g] <= atTerm ? '0 : stageCnt[g] + CW'(1);
      end
    end
  end

  assign imclkEn = stageIn[NUM_STAGES] && !strobes.restart;

  always_ff @(posedge clk) begin
    if (!rstN || strobes.restart) begin
      sampleCnt <= '0;
    end else if (imclkEn) begin
      sampleCnt <= sampleCnt + SW'(1);
    end
  end

  assign fullRateStb = imclkEn && (&sampleCnt);
  assign halfRateStb = imclkEn && (&sampleCnt[HALF_W-1:0]);
  assign sampleStb   = lowDelayEn ? halfRateStb : fullRateStb;

  // R7
  half_in_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    fullRateStb |-> halfRateStb);

  // R9
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restart |=> (sampleCnt == '0 && stageCnt == '0));

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (imclkEn && strobes.termCnt != '0) |=> !imclkEn);

  // R4
  pass_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.restart && strobes.termCnt == '0) |-> imclkEn);

  // R6
  full_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    fullRateStb |=> !fullRateStb);

  // R8
  sample_mux_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> (fullRateStb || (lowDelayEn && halfRateStb)));

endmodule

// File: rtl/mclk_prescale_chain.sv
module mclk_prescale_chain
  import prescale_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] stage1Sel,
  input  logic [SEL_W-1:0] stage2Sel,
  input  logic [SEL_W-1:0] stage3Sel,
  input  logic             lowDelayEn,
  output logic             imclkEn,
  output logic             fullRateStb,
  output logic             halfRateStb,
  output logic             sampleStb
);

  logic [STAGES-1:0][SEL_W-1:0] stageSel;
  ctrlStrobes_t                 strobes;

  assign stageSel = {stage3Sel, stage2Sel, stage1Sel};

  prescale_ctrl #(.NUM_STAGES(STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .stageSel (stageSel),
    .strobes  (strobes)
  );

  prescale_datapath #(
    .NUM_STAGES (STAGES),
    .CW         (CNT_W),
    .SW         (SAMPLE_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .lowDelayEn  (lowDelayEn),
    .imclkEn     (imclkEn),
    .fullRateStb (fullRateStb),
    .halfRateStb (halfRateStb),
    .sampleStb   (sampleStb)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> !(imclkEn || fullRateStb || halfRateStb || sampleStb));

endmodule

// File: tb/mclk_prescale_chain_tb.sv
module mclk_prescale_chain_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] s1 = 2'b00, s2 = 2'b00, s3 = 2'b00;
  logic       lowDelayEn = 1'b0;
  logic       imclkEn, fullRateStb, halfRateStb, sampleStb;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mclk_prescale_chain u_dut (
    .clk(clk), .rstN(rstN),
    .stage1Sel(s1), .stage2Sel(s2), .stage3Sel(s3),
    .lowDelayEn(lowDelayEn),
    .imclkEn(imclkEn), .fullRateStb(fullRateStb),
    .halfRateStb(halfRateStb), .sampleStb(sampleStb)
  );

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive new selects at a negedge, then check the change cycle, the first
  // enable at edge D and the spacing over two more periods.
  task automatic runDivide(input string req, input logic [1:0] a,
                           input logic [1:0] b, input logic [1:0] c,
                           input int expDiv);
    int firstAt = -1;
    int pulses = 0;
    int bad = 0;
    @(negedge clk);
    s1 = a; s2 = b; s3 = c;
    #1;
    check({req, " R9 change cycle quiet"}, int'(imclkEn), 0);
    for (int k = 1; k <= 3 * expDiv; k++) begin
      @(negedge clk);
      if (imclkEn) begin
        pulses++;
        if (firstAt < 0) firstAt = k;
        if (k % expDiv != 0) bad++;
      end else if (k % expDiv == 0) begin
        bad++;
      end
    end
    check({req, " R9 first enable edge"}, firstAt, expDiv);
    check({req, " R5 enable period"}, bad, 0);
    check({req, " R5 enable count"}, pulses, 3);
  endtask

  task automatic testReset();
    rstN = 1'b0; s1 = 2'b00; s2 = 2'b01; s3 = 2'b00;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R1 reset outputs low",
            int'({imclkEn, fullRateStb, halfRateStb, sampleStb}), 0);
    end
    rstN = 1'b1;
    begin
      int firstAt = -1;
      for (int k = 1; k <= 4; k++) begin
        @(negedge clk);
        if (imclkEn && firstAt < 0) firstAt = k;
      end
      check("R1 first enable after release", firstAt, 2);
    end
  endtask

  task automatic testRatios();
    runDivide("R2 stage1 /3",        2'b10, 2'b00, 2'b00, 3);
    runDivide("R2 stage2 /2",        2'b00, 2'b01, 2'b00, 2);
    runDivide("R2 stage2 /3",        2'b00, 2'b10, 2'b00, 3);
    runDivide("R3 stage3 /4",        2'b00, 2'b00, 2'b10, 4);
    runDivide("R3 stage3 /2",        2'b00, 2'b00, 2'b01, 2);
    runDivide("R2 R3 max /36",       2'b10, 2'b10, 2'b10, 36);
    runDivide("R4 spare all /1",     2'b11, 2'b11, 2'b11, 1);
    runDivide("R4 spare mixed /2",   2'b11, 2'b01, 2'b11, 2);
    runDivide("R4 stage3 spare /6",  2'b10, 2'b01, 2'b11, 6);
  endtask

  // Change select in the middle of a count: no early pulse.
  task automatic testMidChange();
    @(negedge clk); s1 = 2'b00; s2 = 2'b00; s3 = 2'b10;
    repeat (6) @(negedge clk);
    runDivide("R9 mid-count change", 2'b10, 2'b00, 2'b10, 12);
  endtask

  task automatic testSampleStrobes();
    int fullAt = -1, halfAt = -1, sampAt = -1, enCount = 0;
    @(negedge clk);
    lowDelayEn = 1'b0;
    s1 = 2'b10; s2 = 2'b01; s3 = 2'b00;
    for (int k = 1; k <= 1536; k++) begin
      @(negedge clk);
      if (imclkEn) enCount++;
      if (fullRateStb && fullAt < 0) fullAt = k;
      if (halfRateStb && halfAt < 0) halfAt = k;
      if (sampleStb && sampAt < 0) sampAt = k;
    end
    check("R10 full strobe at 1536", fullAt, 1536);
    check("R7 half strobe at 768", halfAt, 768);
    check("R8 sampleStb follows full", sampAt, 1536);
    check("R6 256 enables per full strobe", enCount, 256);
  endtask

  task automatic testLowDelay();
    int sampCount = 0, fullCount = 0, firstSamp = -1;
    @(negedge clk);
    lowDelayEn = 1'b1;
    s1 = 2'b00; s2 = 2'b00; s3 = 2'b00;
    for (int k = 1; k <= 512; k++) begin
      @(negedge clk);
      if (sampleStb) begin
        sampCount++;
        if (firstSamp < 0) firstSamp = k;
      end
      if (fullRateStb) fullCount++;
    end
    check("R8 low delay first sample at 128", firstSamp, 128);
    check("R8 low delay sample count", sampCount, 4);
    check("R6 full strobe count", fullCount, 2);
    // Toggle mode without restart: next full strobe stays on schedule.
    lowDelayEn = 1'b0;
    begin
      int at = -1;
      for (int k = 1; k <= 256; k++) begin
        @(negedge clk);
        if (sampleStb && at < 0) at = k;
      end
      check("R8 mode switch keeps count", at, 256);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin : main
    testReset();
    testRatios();
    testMidChange();
    testSampleStrobes();
    testLowDelay();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule